// File: doc/BRIEF.md
# Decimal Text Line Reporter

This block turns numeric result records into readable text for a serial console. Each record holds a small index and two counts. The block converts each binary field to unsigned decimal ASCII in hardware. It then hands the text out one byte at a time on a valid/ready byte interface, which feeds a UART transmitter. Because the text is formed in hardware, the same stream reads correctly in simulation and on the board.

The first record of a session is preceded by a header line. A record flagged as the last one is followed by a closing line. The record after that closing line starts a new session with a fresh header. Records are taken one at a time, and the record input is held off until the current line and any closing line have been fully handed out. The bit-level UART serializer is not part of this block.

Top module: `rpt_reporter`

## Requirements
- R1: After reset the block presents no byte (`tx_valid` low) and is ready for a record (`rec_ready` high).
- R2: The first record accepted after reset is preceded by the header line `BEGIN` plus LF. Later records in the same session carry no header.
- R3: Each record produces exactly the line `" bit <index> hits=<tally> skew=<dev>"` followed by LF. The line starts with one space (0x20), and each label is followed directly by its value.
- R4: Decimal values have no leading zeros, zeros inside a number are kept, and a value of zero prints as the single character `0` (0x30).
- R5: Full-scale inputs print correctly: an index of 255 and counts of 65535 with the default 8-bit index and 16-bit counts.
- R6: `rec_ready` goes low on the cycle after a record is accepted. It stays low until the final LF of that record's output has been handed off, so a record offered in the meantime is not taken early and appears only after the earlier line.
- R7: A record accepted with `rec_last` high is followed by the closing line `END` plus LF. The next record accepted after that is preceded by a new header line.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values into the next cycle.
- R9: The line terminator is a single byte 0x0A, and every other byte sent is printable ASCII (0x20 to 0x7E).
- R10: The first byte of a record's output is presented (`tx_valid` high) in the cycle right after the record handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rec_valid | input | 1 | A record is offered |
| rec_ready | output | 1 | The block can take a record this cycle |
| rec_index | input | IDX_W | Record index field |
| rec_tally | input | VAL_W | Record count field |
| rec_dev | input | VAL_W | Record deviation field |
| rec_last | input | 1 | This record closes the session |
| tx_valid | output | 1 | A text byte is presented |
| tx_ready | input | 1 | The byte sink takes the byte this cycle |
| tx_data | output | 8 | ASCII text byte |

## Verification
The first byte of a record is due one cycle after the record handshake. Each later byte follows one cycle after the handshake of the byte before it. `rec_ready` returns one cycle after the handshake of the final LF. The bench drives and samples on the falling edge, so every value it reads has already settled since the preceding rising edge. Captured bytes are collected only when both `tx_valid` and the bench's own `tx_ready` are high at that falling edge. Whole lines are then compared against text the bench builds itself with decimal formatting. Hold behaviour is checked on each stalled cycle, and the ready gap is checked at the exact falling edge where `rec_ready` comes back.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic [3:0] {
    SEG_HEAD, SEG_PRE, SEG_IDX, SEG_TLAB, SEG_TVAL,
    SEG_DLAB, SEG_DVAL, SEG_EOL, SEG_TAIL
  } seg_e;

  localparam logic [7:0] CH_LF   = 8'h0A;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam int         TXT_MAX = 6;

  // decimal digits needed for the largest unsigned value of w bits
  function automatic int dec_digits(input int w);
    longint unsigned m;
    int n;
    m = (64'd1 << w) - 64'd1;
    n = 1;
    m = m / 10;
    while (m != 0) begin
      n = n + 1;
      m = m / 10;
    end
    return n;
  endfunction

  function automatic seg_e seg_after(input seg_e s);
    case (s)
      SEG_HEAD: return SEG_PRE;
      SEG_PRE:  return SEG_IDX;
      SEG_IDX:  return SEG_TLAB;
      SEG_TLAB: return SEG_TVAL;
      SEG_TVAL: return SEG_DLAB;
      SEG_DLAB: return SEG_DVAL;
      SEG_DVAL: return SEG_EOL;
      default:  return SEG_TAIL;
    endcase
  endfunction

  function automatic logic seg_numeric(input seg_e s);
    return (s == SEG_IDX) || (s == SEG_TVAL) || (s == SEG_DVAL);
  endfunction

endpackage

// File: rtl/rpt_bcd.sv
module rpt_bcd #(
  parameter int W  = 16,
  parameter int ND = 5,
  parameter int PW = 3
) (
  input  logic [W-1:0]    bin,
  output logic [4*ND-1:0] bcd,
  output logic [PW-1:0]   msd
);
  localparam int SW = W + 4*ND;

  logic [SW-1:0] sh;

  // shift-and-add-three conversion, fully combinational
  always_comb begin
    sh = '0;
    sh[W-1:0] = bin;
    for (int i = 0; i < W; i++) begin
      for (int d = 0; d < ND; d++) begin
        if (sh[W+4*d +: 4] > 4'd4)
          sh[W+4*d +: 4] = sh[W+4*d +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
  end

  assign bcd = sh[W +: 4*ND];

  // position of the most significant non-zero digit (0 for a zero value)
  always_comb begin
    msd = '0;
    for (int d = 0; d < ND; d++) begin
      if (bcd[4*d +: 4] != 4'd0) msd = PW'(d);
    end
  end

endmodule

// File: rtl/rpt_text.sv
module rpt_text
  import rpt_pkg::*;
#(
  parameter int NDI = 3,
  parameter int NDV = 5,
  parameter int PW  = 3
) (
  input  seg_e             seg,
  input  logic [PW-1:0]    pos,
  input  logic [4*NDI-1:0] idx_bcd,
  input  logic [4*NDV-1:0] tal_bcd,
  input  logic [4*NDV-1:0] dev_bcd,
  output logic [7:0]       chr,
  output logic             seg_end
);
  localparam logic [8*TXT_MAX-1:0] TXT_HEAD = "BEGIN\n";
  localparam logic [8*TXT_MAX-1:0] TXT_PRE  = " bit ";
  localparam logic [8*TXT_MAX-1:0] TXT_TLAB = " hits=";
  localparam logic [8*TXT_MAX-1:0] TXT_DLAB = " skew=";
  localparam logic [8*TXT_MAX-1:0] TXT_TAIL = "END\n";

  function automatic logic [7:0] str_char(input logic [8*TXT_MAX-1:0] s,
                                          input int len,
                                          input logic [PW-1:0] p);
    int k;
    k = len - 1 - int'(p);
    if (k < 0) return 8'h3F;
    return s[8*k +: 8];
  endfunction

  function automatic logic [7:0] dig_char(input logic [3:0] d);
    return CH_ZERO + {4'h0, d};
  endfunction

  always_comb begin
    chr     = CH_LF;
    seg_end = 1'b1;
    case (seg)
      SEG_HEAD: begin chr = str_char(TXT_HEAD, 6, pos); seg_end = (pos == PW'(5)); end
      SEG_PRE:  begin chr = str_char(TXT_PRE,  5, pos); seg_end = (pos == PW'(4)); end
      SEG_TLAB: begin chr = str_char(TXT_TLAB, 6, pos); seg_end = (pos == PW'(5)); end
      SEG_DLAB: begin chr = str_char(TXT_DLAB, 6, pos); seg_end = (pos == PW'(5)); end
      SEG_TAIL: begin chr = str_char(TXT_TAIL, 4, pos); seg_end = (pos == PW'(3)); end
      SEG_IDX:  begin chr = dig_char(idx_bcd[4*pos +: 4]); seg_end = (pos == '0); end
      SEG_TVAL: begin chr = dig_char(tal_bcd[4*pos +: 4]); seg_end = (pos == '0); end
      SEG_DVAL: begin chr = dig_char(dev_bcd[4*pos +: 4]); seg_end = (pos == '0); end
      default:  begin chr = CH_LF; seg_end = 1'b1; end
    endcase
  end

endmodule

// File: rtl/rpt_reporter.sv
module rpt_reporter
  import rpt_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  output logic             rec_ready,
  input  logic [IDX_W-1:0] rec_index,
  input  logic [VAL_W-1:0] rec_tally,
  input  logic [VAL_W-1:0] rec_dev,
  input  logic             rec_last,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data
);
  localparam int ND_I   = dec_digits(IDX_W);
  localparam int ND_V   = dec_digits(VAL_W);
  localparam int MAX_DV = (ND_V > ND_I) ? ND_V : ND_I;
  localparam int MAXLEN = (MAX_DV > TXT_MAX) ? MAX_DV : TXT_MAX;
  localparam int PW     = $clog2(MAXLEN);

  // reset synchronizer: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic             busy_q, busy_n;
  logic             hdr_q, hdr_n;
  logic             last_q, last_n;
  seg_e             seg_q, seg_n, seg_nx;
  logic [PW-1:0]    pos_q, pos_n;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] tal_q, dev_q;

  logic [4*ND_I-1:0] idx_bcd;
  logic [4*ND_V-1:0] tal_bcd, dev_bcd;
  logic [PW-1:0]     idx_msd, tal_msd, dev_msd;
  logic [7:0]        chr;
  logic              seg_end;
  logic              ld, adv, en;

  rpt_bcd #(.W(IDX_W), .ND(ND_I), .PW(PW)) u_bcd_idx (.bin(idx_q), .bcd(idx_bcd), .msd(idx_msd));
  rpt_bcd #(.W(VAL_W), .ND(ND_V), .PW(PW)) u_bcd_tal (.bin(tal_q), .bcd(tal_bcd), .msd(tal_msd));
  rpt_bcd #(.W(VAL_W), .ND(ND_V), .PW(PW)) u_bcd_dev (.bin(dev_q), .bcd(dev_bcd), .msd(dev_msd));

  rpt_text #(.NDI(ND_I), .NDV(ND_V), .PW(PW)) u_text (
    .seg(seg_q), .pos(pos_q), .idx_bcd(idx_bcd), .tal_bcd(tal_bcd),
    .dev_bcd(dev_bcd), .chr(chr), .seg_end(seg_end)
  );

  assign ld  = !busy_q && rec_valid;
  assign adv = busy_q && tx_ready;
  assign en  = ld || adv;

  // next-state logic
  always_comb begin
    busy_n = busy_q;
    hdr_n  = hdr_q;
    last_n = last_q;
    seg_n  = seg_q;
    pos_n  = pos_q;
    seg_nx = seg_after(seg_q);
    if (ld) begin
      busy_n = 1'b1;
      hdr_n  = 1'b0;
      last_n = rec_last;
      seg_n  = hdr_q ? SEG_HEAD : SEG_PRE;
      pos_n  = '0;
    end else if (adv) begin
      if (!seg_end) begin
        pos_n = seg_numeric(seg_q) ? (pos_q - PW'(1)) : (pos_q + PW'(1));
      end else if (seg_q == SEG_EOL) begin
        if (last_q) begin
          seg_n = SEG_TAIL;
          pos_n = '0;
        end else begin
          busy_n = 1'b0;
        end
      end else if (seg_q == SEG_TAIL) begin
        busy_n = 1'b0;
        hdr_n  = 1'b1;
      end else begin
        seg_n = seg_nx;
        case (seg_nx)
          SEG_IDX:  pos_n = idx_msd;
          SEG_TVAL: pos_n = tal_msd;
          SEG_DVAL: pos_n = dev_msd;
          default:  pos_n = '0;
        endcase
      end
    end
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q <= 1'b0;
      hdr_q  <= 1'b1;
      last_q <= 1'b0;
      seg_q  <= SEG_HEAD;
      pos_q  <= '0;
    end else if (en) begin
      busy_q <= busy_n;
      hdr_q  <= hdr_n;
      last_q <= last_n;
      seg_q  <= seg_n;
      pos_q  <= pos_n;
    end
  end

  // record field capture
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      idx_q <= '0;
      tal_q <= '0;
      dev_q <= '0;
    end else if (ld) begin
      idx_q <= rec_index;
      tal_q <= rec_tally;
      dev_q <= rec_dev;
    end
  end

  assign rec_ready = !busy_q;
  assign tx_valid  = busy_q;
  assign tx_data   = chr;

endmodule

// File: rtl/rpt_reporter_chk.sv
module rpt_reporter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rec_valid,
  input logic       rec_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data
);

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready |=> !rec_ready);

  a_r6_busy_until_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_ready && !(tx_valid && tx_ready) |=> !rec_ready);

  a_r10_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready |=> tx_valid);

  a_r9_charset: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data == 8'h0A) || (tx_data >= 8'h20 && tx_data <= 8'h7E));

endmodule

bind rpt_reporter rpt_reporter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
);

// File: tb/rpt_reporter_tb_top.sv
module rpt_reporter_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rec_valid = 1'b0;
  logic       rec_ready;
  logic [7:0] rec_index = '0;
  logic [15:0] rec_tally = '0;
  logic [15:0] rec_dev = '0;
  logic       rec_last = 1'b0;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stall_mode = 0;
  bit finished = 0;
  bit hold_chk = 0;
  logic [7:0] held = '0;
  byte unsigned cap[$];

  always #(CLK_P/2) clk = ~clk;

  rpt_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_index(rec_index), .rec_tally(rec_tally), .rec_dev(rec_dev),
    .rec_last(rec_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );

  // byte sink: drives tx_ready and captures handshaken bytes at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (hold_chk) begin
      total = total + 1;
      if (!(tx_valid && tx_data == held)) begin
        bad = bad + 1;
        $display("FAIL R8: valid=%0b data=%02h expected valid=1 data=%02h", tx_valid, tx_data, held);
      end
    end
    tx_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
    if (tx_valid && tx_ready) begin
      if (!(tx_data == 8'h0A || (tx_data >= 8'h20 && tx_data <= 8'h7E))) begin
        total = total + 1;
        bad = bad + 1;
        $display("FAIL R9: byte %02h expected printable or 0A", tx_data);
      end
      cap.push_back(tx_data);
    end
    hold_chk = tx_valid && !tx_ready;
    held = tx_data;
  end

  function automatic string vis(input string s);
    string o = "";
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == 8'h0A) o = {o, "\\n"};
      else o = {o, string'(s[i])};
    end
    return o;
  endfunction

  function automatic string cap_str();
    string o = "";
    foreach (cap[i]) o = {o, string'(cap[i])};
    return o;
  endfunction

  function automatic string line(input int i, input int t, input int d);
    return $sformatf(" bit %0d hits=%0d skew=%0d\n", i, t, d);
  endfunction

  task automatic check_text(input string exp, input string tag);
    string got;
    got = cap_str();
    total = total + 1;
    if (got != exp) begin
      bad = bad + 1;
      $display("FAIL %s: got \"%s\" expected \"%s\"", tag, vis(got), vis(exp));
    end
    cap.delete();
  endtask

  // offer one record at a falling edge; returns one cycle after acceptance
  task automatic send_rec(input int i, input int t, input int d, input bit last);
    rec_index = 8'(i);
    rec_tally = 16'(t);
    rec_dev   = 16'(d);
    rec_last  = last;
    rec_valid = 1'b1;
    while (!rec_ready) @(negedge clk);
    @(negedge clk);
    rec_valid = 1'b0;
    total = total + 1;
    if (!(tx_valid && !rec_ready)) begin
      bad = bad + 1;
      $display("FAIL R10: tx_valid=%0b rec_ready=%0b expected 1/0", tx_valid, rec_ready);
    end
  endtask

  task automatic wait_done();
    while (!rec_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    total = total + 1;
    if (tx_valid !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R1: tx_valid=%0b in reset expected 0", tx_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total = total + 1;
    if (!(rec_ready === 1'b1 && tx_valid === 1'b0)) begin
      bad = bad + 1;
      $display("FAIL R1: rec_ready=%0b tx_valid=%0b expected 1/0", rec_ready, tx_valid);
    end
  endtask

  task automatic t_first();
    stall_mode = 0;
    send_rec(3, 4958, 42, 0);
    wait_done();
    check_text({"BEGIN\n", line(3, 4958, 42)}, "R2 R3 header and line");
  endtask

  task automatic t_zero();
    stall_mode = 1;
    send_rec(0, 0, 0, 0);
    wait_done();
    check_text(line(0, 0, 0), "R4 zero values, R2 no repeat header");
    send_rec(10, 100, 1000, 0);
    wait_done();
    check_text(line(10, 100, 1000), "R4 inner zeros");
    send_rec(7, 10005, 9, 0);
    wait_done();
    check_text(line(7, 10005, 9), "R4 mixed widths");
  endtask

  task automatic t_max();
    stall_mode = 1;
    send_rec(255, 65535, 65535, 0);
    wait_done();
    check_text(line(255, 65535, 65535), "R5 full scale");
    stall_mode = 0;
    send_rec(31, 65535, 1, 0);
    wait_done();
    check_text(line(31, 65535, 1), "R5 full scale count");
  endtask

  task automatic t_backtoback();
    int len1;
    stall_mode = 1;
    len1 = line(1, 11, 22).len();
    send_rec(1, 11, 22, 0);
    rec_index = 8'd2;
    rec_tally = 16'd33;
    rec_dev   = 16'd44;
    rec_last  = 1'b0;
    rec_valid = 1'b1;
    while (!rec_ready) @(negedge clk);
    total = total + 1;
    if (!(cap.size() == len1 && cap[cap.size()-1] == 8'h0A)) begin
      bad = bad + 1;
      $display("FAIL R6: ready back after %0d bytes expected %0d ending 0A", cap.size(), len1);
    end
    @(negedge clk);
    rec_valid = 1'b0;
    wait_done();
    check_text({line(1, 11, 22), line(2, 33, 44)}, "R6 held record order");
  endtask

  task automatic t_last();
    stall_mode = 1;
    send_rec(5, 123, 45, 1);
    wait_done();
    check_text({line(5, 123, 45), "END\n"}, "R7 closing line");
    stall_mode = 0;
    send_rec(6, 9, 8, 0);
    wait_done();
    check_text({"BEGIN\n", line(6, 9, 8)}, "R7 new header");
  endtask

  initial begin
    t_reset();
    t_first();
    t_zero();
    t_max();
    t_backtoback();
    t_last();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule